// File: doc/BRIEF.md
# Multi-Slot Reorder Buffer Retire Unit

This block keeps the program order of in-flight instructions in a circular buffer of `CAPACITY` slots. An instruction claims a run of adjacent slots as wide as its micro-op count. It receives a token, which is the index of the first slot of that run. An instruction with no micro-ops still claims one slot, and a count larger than the buffer is cut down to the buffer size. Both the allocation pointer and the head pointer step by whole entries. They wrap at `CAPACITY` by a compare-and-subtract, so the capacity does not have to be a power of two.

Execution units report completion by presenting the token on the execute port, which marks that entry as executed. Each cycle the retire logic starts at the head and retires a run of executed entries in program order. It stops at the first entry that is not yet executed, at an empty slot, or at `MAX_RETIRE` entries. A `MAX_RETIRE` of 0 allows up to `CAPACITY` retirements per cycle. The retired tokens appear on parallel lanes in the cycle before the state update. Retiring an entry returns all of its slots to the free count.

Top module: `rob_retire_unit`

## Requirements
- R1: After reset the free count equals `CAPACITY`, the allocation token is 0 and no retire lane is valid.
- R2: A request for `u` micro-ops claims `max(1, min(u, CAPACITY))` slots; a zero request takes one slot and an oversized request takes the whole buffer.
- R3: `rsvToken` shows the current allocation index; an accepted reservation advances it by the claimed slot count, modulo `CAPACITY`.
- R4: `rsvReady` is high exactly when the free count is at least the normalized slot count; a request presented while `rsvReady` is low changes neither the token nor the free count.
- R5: The free count drops by the claimed slot count on an accepted reservation and rises by each retired entry's slot count; in a cycle with both, the net change applies.
- R6: An entry retires only after an execute event carrying its token, and never before an older unexecuted entry, even if younger entries have executed.
- R7: No more than `MAX_RETIRE` entries retire in one cycle (0 means up to `CAPACITY`); executed entries beyond the limit retire in later cycles.
- R8: `retValid` is a contiguous run of ones starting at lane 0; lane i of `retTokens` (bits `i*IDX_W` upward) carries the token of the i-th retired entry, oldest first, and the head moves by each retired entry's slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rsvValid | input | 1 | Reservation request |
| rsvUops | input | UOP_W | Micro-op count of the request |
| rsvReady | output | 1 | Request can be accepted this cycle |
| rsvToken | output | IDX_W | Token given to a request accepted this cycle |
| freeSlots | output | CNT_W | Number of free slots |
| exeValid | input | 1 | Execute-complete event |
| exeToken | input | IDX_W | Token of the completed entry |
| retValid | output | RET_LANES | Per-lane retire strobe for this cycle |
| retTokens | output | RET_LANES*IDX_W | Tokens of the entries retiring this cycle |

## Verification
The bench targets the following corner cases:
- Zero-op and oversized requests. A design that skipped the one-slot minimum would hand two entries the same token. A design that skipped the clamp would leave the free count wrapped.
- A request arriving when the free count is one slot short. Accepting it would overwrite live entries.
- Younger entries that execute first. Retiring them early breaks program order.
- Runs of executed entries longer than the lane limit, which expose a retire loop that ignores the limit.
- Pointer wrap at a non-power-of-two capacity. A design that wraps by bit masking produces tokens at or above the capacity.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic rsvEn;
    logic exeEn;
    logic retAny;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int CAPACITY  = 6,
  parameter int UOP_W     = 4,
  parameter int RET_LANES = 2,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 3
) (
  input  logic                       rsvValid,
  input  logic [UOP_W-1:0]           rsvUops,
  input  logic                       exeValid,
  input  logic [IDX_W-1:0]           exeToken,
  input  logic [IDX_W-1:0]           head,
  input  logic [IDX_W-1:0]           tail,
  input  logic [CNT_W-1:0]           freeCnt,
  input  logic                       entLive [CAPACITY],
  input  logic                       entExec [CAPACITY],
  input  logic [CNT_W-1:0]           entSlots[CAPACITY],
  output robStrobe_t                 strobe,
  output logic                       rsvReady,
  output logic [CNT_W-1:0]           rsvSlots,
  output logic [IDX_W-1:0]           tailNext,
  output logic [IDX_W-1:0]           headNext,
  output logic [CNT_W-1:0]           retSlots,
  output logic                       retClr  [CAPACITY],
  output logic [RET_LANES-1:0]       retValid,
  output logic [RET_LANES*IDX_W-1:0] retTokens
);
  // step an index forward by n slots, wrapping without a modulo operator
  function automatic logic [IDX_W-1:0] advance(logic [IDX_W-1:0] idx, logic [CNT_W-1:0] n);
    logic [CNT_W:0] sum;
    sum = (CNT_W+1)'(idx) + (CNT_W+1)'(n);
    if (sum >= (CNT_W+1)'(CAPACITY)) sum = sum - (CNT_W+1)'(CAPACITY);
    return sum[IDX_W-1:0];
  endfunction

  always_comb begin
    if (rsvUops == '0)
      rsvSlots = CNT_W'(1);
    else if (int'(rsvUops) > CAPACITY)
      rsvSlots = CNT_W'(CAPACITY);
    else
      rsvSlots = CNT_W'(rsvUops);
  end

  assign rsvReady     = (freeCnt >= rsvSlots);
  assign strobe.rsvEn = rsvValid && rsvReady;
  assign strobe.exeEn = exeValid && (int'(exeToken) < CAPACITY);
  assign tailNext     = advance(tail, rsvSlots);

  always_comb begin
    logic [IDX_W-1:0] ptr;
    logic             go;
    ptr       = head;
    go        = 1'b1;
    retSlots  = '0;
    retValid  = '0;
    retTokens = '0;
    for (int c = 0; c < CAPACITY; c++) retClr[c] = 1'b0;
    for (int i = 0; i < RET_LANES; i++) begin
      retTokens[i*IDX_W +: IDX_W] = ptr;
      if (go && entLive[ptr] && entExec[ptr] && !retClr[ptr]) begin
        retValid[i] = 1'b1;
        retClr[ptr] = 1'b1;
        retSlots    = retSlots + entSlots[ptr];
        ptr         = advance(ptr, entSlots[ptr]);
      end else begin
        go = 1'b0;
      end
    end
    headNext      = ptr;
    strobe.retAny = retValid[0];
  end
endmodule

// File: rtl/rob_dp.sv
module rob_dp
  import rob_pkg::*;
#(
  parameter int CAPACITY = 6,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  robStrobe_t       strobe,
  input  logic [CNT_W-1:0] rsvSlots,
  input  logic [IDX_W-1:0] tailNext,
  input  logic [IDX_W-1:0] headNext,
  input  logic [CNT_W-1:0] retSlots,
  input  logic             retClr  [CAPACITY],
  input  logic [IDX_W-1:0] exeToken,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] freeCnt,
  output logic             entLive [CAPACITY],
  output logic             entExec [CAPACITY],
  output logic [CNT_W-1:0] entSlots[CAPACITY]
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      head    <= '0;
      tail    <= '0;
      freeCnt <= CNT_W'(CAPACITY);
      for (int i = 0; i < CAPACITY; i++) begin
        entLive[i]  <= 1'b0;
        entExec[i]  <= 1'b0;
        entSlots[i] <= '0;
      end
    end else begin
      if (strobe.retAny) begin
        head <= headNext;
        for (int i = 0; i < CAPACITY; i++) begin
          if (retClr[i]) begin
            entLive[i] <= 1'b0;
            entExec[i] <= 1'b0;
          end
        end
      end
      if (strobe.exeEn) entExec[exeToken] <= 1'b1;
      if (strobe.rsvEn) begin
        entSlots[tail] <= rsvSlots;
        entExec[tail]  <= 1'b0;
        entLive[tail]  <= 1'b1;
        tail           <= tailNext;
      end
      freeCnt <= freeCnt - (strobe.rsvEn ? rsvSlots : '0) + retSlots;
    end
  end
endmodule

// File: rtl/rob_retire_unit.sv
module rob_retire_unit
  import rob_pkg::*;
#(
  parameter int CAPACITY   = 6,
  parameter int MAX_RETIRE = 2,
  parameter int UOP_W      = 4,
  localparam int IDX_W     = (CAPACITY > 1) ? $clog2(CAPACITY) : 1,
  localparam int CNT_W     = $clog2(CAPACITY + 1),
  localparam int RET_LANES = (MAX_RETIRE == 0 || MAX_RETIRE > CAPACITY) ? CAPACITY : MAX_RETIRE
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rsvValid,
  input  logic [UOP_W-1:0]           rsvUops,
  output logic                       rsvReady,
  output logic [IDX_W-1:0]           rsvToken,
  output logic [CNT_W-1:0]           freeSlots,
  input  logic                       exeValid,
  input  logic [IDX_W-1:0]           exeToken,
  output logic [RET_LANES-1:0]       retValid,
  output logic [RET_LANES*IDX_W-1:0] retTokens
);
  robStrobe_t       strobe;
  logic [CNT_W-1:0] rsvSlots, retSlots, freeCnt;
  logic [IDX_W-1:0] head, tail, headNext, tailNext;
  logic             retClr  [CAPACITY];
  logic             entLive [CAPACITY];
  logic             entExec [CAPACITY];
  logic [CNT_W-1:0] entSlots[CAPACITY];

  rob_ctrl #(
    .CAPACITY(CAPACITY), .UOP_W(UOP_W), .RET_LANES(RET_LANES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .rsvValid(rsvValid), .rsvUops(rsvUops), .exeValid(exeValid), .exeToken(exeToken),
    .head(head), .tail(tail), .freeCnt(freeCnt),
    .entLive(entLive), .entExec(entExec), .entSlots(entSlots),
    .strobe(strobe), .rsvReady(rsvReady), .rsvSlots(rsvSlots),
    .tailNext(tailNext), .headNext(headNext), .retSlots(retSlots),
    .retClr(retClr), .retValid(retValid), .retTokens(retTokens)
  );

  rob_dp #(
    .CAPACITY(CAPACITY), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rsvSlots(rsvSlots),
    .tailNext(tailNext), .headNext(headNext), .retSlots(retSlots),
    .retClr(retClr), .exeToken(exeToken),
    .head(head), .tail(tail), .freeCnt(freeCnt),
    .entLive(entLive), .entExec(entExec), .entSlots(entSlots)
  );

  assign rsvToken  = tail;
  assign freeSlots = freeCnt;
endmodule

// File: rtl/rob_retire_unit_chk.sv
module rob_retire_unit_chk #(
  parameter int CAPACITY  = 6,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 3,
  parameter int RET_LANES = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       rsvValid,
  input logic                       rsvReady,
  input logic [IDX_W-1:0]           rsvToken,
  input logic [CNT_W-1:0]           freeSlots,
  input logic [RET_LANES-1:0]       retValid,
  input logic [RET_LANES*IDX_W-1:0] retTokens
);
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeSlots) <= CAPACITY); // R5
  AST_TOKEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(rsvToken) < CAPACITY); // R3
  AST_REJECT_HOLD_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    (rsvValid && !rsvReady) |=> $stable(rsvToken)); // R4
  AST_REJECT_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!(rsvValid && rsvReady)) |=> (freeSlots >= $past(freeSlots))); // R4
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (freeSlots == '0) |-> !rsvReady); // R4
  AST_RET_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    ((retValid + 1'b1) & retValid) == '0); // R8
  AST_RET_FIRST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    retValid[0] |-> (int'(retTokens[IDX_W-1:0]) < CAPACITY)); // R8
  AST_RET_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    retValid[0] |-> (int'(freeSlots) < CAPACITY)); // R6
endmodule

bind rob_retire_unit rob_retire_unit_chk #(
  .CAPACITY(CAPACITY), .IDX_W(IDX_W), .CNT_W(CNT_W), .RET_LANES(RET_LANES)
) u_chk (
  .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvReady(rsvReady),
  .rsvToken(rsvToken), .freeSlots(freeSlots), .retValid(retValid), .retTokens(retTokens)
);

// File: tb/rob_retire_unit_tb.sv
`timescale 1ns/1ps
module rob_retire_unit_tb;
  localparam int CAPACITY   = 6;
  localparam int MAX_RETIRE = 2;
  localparam int UOP_W      = 4;
  localparam int IDX_W      = (CAPACITY > 1) ? $clog2(CAPACITY) : 1;
  localparam int CNT_W      = $clog2(CAPACITY + 1);
  localparam int RET_LANES  = (MAX_RETIRE == 0 || MAX_RETIRE > CAPACITY) ? CAPACITY : MAX_RETIRE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rsvValid = 1'b0;
  logic [UOP_W-1:0] rsvUops = '0;
  logic rsvReady;
  logic [IDX_W-1:0] rsvToken;
  logic [CNT_W-1:0] freeSlots;
  logic exeValid = 1'b0;
  logic [IDX_W-1:0] exeToken = '0;
  logic [RET_LANES-1:0] retValid;
  logic [RET_LANES*IDX_W-1:0] retTokens;

  always #2.5 clk = ~clk;

  rob_retire_unit #(.CAPACITY(CAPACITY), .MAX_RETIRE(MAX_RETIRE), .UOP_W(UOP_W)) u_dut (
    .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvUops(rsvUops), .rsvReady(rsvReady),
    .rsvToken(rsvToken), .freeSlots(freeSlots), .exeValid(exeValid), .exeToken(exeToken),
    .retValid(retValid), .retTokens(retTokens)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  int mSlots[CAPACITY];
  bit mExec[CAPACITY];
  bit mLive[CAPACITY];
  int mHead, mTail, mFree;

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int normSlots(int u);
    if (u == 0) return 1;
    if (u > CAPACITY) return CAPACITY;
    return u;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < CAPACITY; i++) begin
      mSlots[i] = 0; mExec[i] = 0; mLive[i] = 0;
    end
    mHead = 0; mTail = 0; mFree = CAPACITY;
  endtask

  // one cycle: drive after negedge, compare mid-cycle, update model at the edge
  task automatic step(bit rv, int uops, bit ev, int etok);
    int s, ptr, rs, n;
    bit expReady, go;
    bit clr[CAPACITY];
    rsvValid = rv; rsvUops = UOP_W'(uops); exeValid = ev; exeToken = IDX_W'(etok);
    #1;
    s = normSlots(uops);
    expReady = (mFree >= s);
    check("R4", int'(rsvReady), int'(expReady), "rsvReady");
    check("R3", int'(rsvToken), mTail, "rsvToken");
    check("R5", int'(freeSlots), mFree, "freeSlots");
    for (int i = 0; i < CAPACITY; i++) clr[i] = 0;
    ptr = mHead; go = 1; rs = 0; n = 0;
    for (int l = 0; l < RET_LANES; l++) begin
      if (go && mLive[ptr] && mExec[ptr] && !clr[ptr]) begin
        check("R8", int'(retTokens[l*IDX_W +: IDX_W]), ptr, "retire token");
        clr[ptr] = 1; rs += mSlots[ptr]; ptr = (ptr + mSlots[ptr]) % CAPACITY; n++;
      end else go = 0;
    end
    check("R6", int'(retValid), (1 << n) - 1, "retire mask");
    check("R7", $countones(retValid), n, "retire count");
    @(posedge clk);
    for (int i = 0; i < CAPACITY; i++) if (clr[i]) begin mLive[i] = 0; mExec[i] = 0; end
    if (n > 0) mHead = ptr;
    if (ev && etok < CAPACITY) mExec[etok] = 1;
    if (rv && expReady) begin
      mSlots[mTail] = s; mExec[mTail] = 0; mLive[mTail] = 1;
      mTail = (mTail + s) % CAPACITY;
    end
    mFree = mFree - ((rv && expReady) ? s : 0) + rs;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; rsvValid = 0; exeValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    #1;
    check("R1", int'(freeSlots), CAPACITY, "reset freeSlots");
    check("R1", int'(rsvToken), 0, "reset token");
    check("R1", int'(retValid), 0, "reset retValid");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int tok, cnt, pick;
    bit ev;
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // R2: zero-op request takes one slot
    step(1, 0, 0, 0);
    #1;
    check("R2", int'(freeSlots), CAPACITY - 1, "zero-op free");
    check("R2", int'(rsvToken), 1, "zero-op next token");
    step(1, 3, 0, 0);              // token 1, free 2
    step(1, 4, 0, 0);              // R4: short by two, rejected
    #1;
    check("R4", int'(rsvToken), 4, "token held after reject");
    check("R4", int'(freeSlots), 2, "free held after reject");
    step(1, 2, 1, 1);              // R3: token 4 wraps to 0; younger entry executes
    #1;
    check("R3", int'(rsvToken), 0, "wrapped token");
    check("R6", int'(retValid), 0, "younger executed, older pending");
    step(0, 0, 1, 0);              // execute head
    step(0, 0, 1, 4);              // two retire, third executed
    #1;
    check("R7", int'(retValid), 1, "third entry deferred to next cycle");
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // R2: oversized request on an empty buffer takes all slots
    step(1, 9, 0, 0);
    #1;
    check("R2", int'(freeSlots), 0, "oversized free");
    check("R4", int'(rsvReady), 0, "ready low when full");
    step(1, 0, 1, int'(rsvToken) == 0 ? 0 : 0);
    step(0, 0, 0, 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      cnt = 0; pick = 0; ev = 0; tok = 0;
      for (int i = 0; i < CAPACITY; i++) if (mLive[i] && !mExec[i]) cnt++;
      if (cnt > 0 && ($urandom % 3) != 0) begin
        pick = $urandom % cnt;
        for (int i = 0; i < CAPACITY; i++) begin
          if (mLive[i] && !mExec[i]) begin
            if (pick == 0) begin tok = i; ev = 1; end
            pick--;
          end
        end
      end
      step(($urandom % 3) != 0, $urandom % 9, ev, tok);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule